// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block sits between instruction decode and issue and acts as a sub-program-counter. It takes one scalar-form operation and expands it into a series of element operations across a vector length. Each operand (the destination and two sources) carries a flag that marks it scalar or vector. A vector operand's register number steps by one per element. A scalar operand keeps its base register. A predicate mask can hold back individual elements, and a reverse flag runs the loop from the top element down to element zero.

While the loop runs, each cycle handles one step. If that step's element is enabled, the block emits an issue record: the element index and the three effective register numbers. A scalar destination normally ends the loop after the first element that is actually issued. With map-reduce set, the loop runs to the end, and every element targets the same scalar register, which acts as an accumulator. The step counter is visible on a port at all times. An abort (interrupt) stops the loop with the counter intact. A later start with the resume flag set continues the loop from that element. A new operation is accepted only while the block is idle, and the end of each completed operation is marked by a one-cycle done pulse.

The controller has three states. IDLE waits for a start. RUN handles one step per cycle. FINISH drives the done pulse. The transitions are as follows:
- IDLE→RUN on an accepted start with a nonzero length.
- IDLE→FINISH on an accepted start with zero length.
- RUN→RUN while further steps remain.
- RUN→FINISH after the last step, or after the first issued element when the destination is scalar and map-reduce is off.
- RUN→IDLE on abort.
- FINISH→IDLE always.

Top module: `vloop_seq`

## Requirements
- R1: `op_start` is accepted only in IDLE (`busy`=0). It is ignored while `busy`=1. `busy` is 1 from the cycle after acceptance until `done` has been pulsed.
- R2: With `pred_en`=0 every element is enabled, whatever value `pred_mask` holds.
- R3: With `pred_en`=1, an element whose bit `pred_mask[idx]` is 0 produces no issue (`iss_valid`=0), yet its step still takes one cycle and advances the counter.
- R4: A vector operand's register number is its base plus the element index, modulo 2^REG_W. A scalar operand's register number is its base.
- R5: With a scalar destination and `map_reduce`=0, the loop ends after the first issued element, and `done` pulses in the next cycle.
- R6: With a scalar destination and `map_reduce`=1, every enabled element is issued in order, and all of them carry the destination base register.
- R7: With `rev_order`=1, step s handles element VL-1-s. Otherwise it handles element s.
- R8: All vector operands of one issue use the same element index. A vector destination with two scalar sources therefore writes the same operation into every enabled element (splat).
- R9: `loop_step` shows the step being handled in RUN. It is 0 at reset and in the cycle `done` is high.
- R10: `op_abort` in RUN suppresses that cycle's issue and returns the block to IDLE without a `done` pulse. `loop_step` keeps the aborted step.
- R11: A start with `op_resume`=1 begins at the current `loop_step` rather than at 0.
- R12: A start with VL=0 issues nothing, and `done` pulses in the cycle after acceptance.
- R13: `done` is a single-cycle pulse. For an operation that runs to the end, it follows the last step's cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Request to start an operation |
| op_resume | input | 1 | With start: continue from `loop_step` |
| op_abort | input | 1 | Stop the running loop (interrupt) |
| op_vl | input | VL_W | Vector length, 0..MAXVL |
| dst_vec | input | 1 | Destination is a vector |
| srca_vec | input | 1 | Source A is a vector |
| srcb_vec | input | 1 | Source B is a vector |
| dst_base | input | REG_W | Destination base register |
| srca_base | input | REG_W | Source A base register |
| srcb_base | input | REG_W | Source B base register |
| pred_en | input | 1 | Predicate mask in use |
| pred_mask | input | MAXVL | Predicate, one bit per element |
| map_reduce | input | 1 | Keep looping on a scalar destination |
| rev_order | input | 1 | Run from element VL-1 down to 0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| iss_valid | output | 1 | Issue record valid this cycle |
| iss_idx | output | STEP_W | Element index of the issue |
| iss_dst | output | REG_W | Effective destination register |
| iss_srca | output | REG_W | Effective source A register |
| iss_srcb | output | REG_W | Effective source B register |
| loop_step | output | STEP_W | Visible resumable step counter |

## Verification
The assertions assume that a resumed start uses a length greater than the saved step, so the step stays below VL throughout RUN. The stimulus honours this by resuming only with the length that was aborted. They also assume that abort is raised only while the loop is running. The sweeps cover every length from 0 to 8, both directions, four operand/mode mixes and several mask shapes. The expected sequence for each of them is derived arithmetically from the mode bits.

// File: rtl/vloop_pkg.sv
package vloop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } vl_state_e;
endpackage

// File: rtl/vloop_ctrl.sv
module vloop_ctrl
    import vloop_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              resume,
    input  logic              abort,
    input  logic              vl_zero,
    input  logic              last_step,
    input  logic              stop_early,
    output logic              load,
    output logic              running,
    output logic              busy,
    output logic              done,
    output logic [STEP_W-1:0] step
);
    vl_state_e         state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;

    // next-state and next-step selection
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (vl_zero) begin
                        state_d = ST_FINISH;
                        step_d  = '0;
                    end else begin
                        state_d = ST_RUN;
                        step_d  = resume ? step_q : '0;
                    end
                end
            end
            ST_RUN: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (last_step || stop_early) begin
                    state_d = ST_FINISH;
                    step_d  = '0;
                end else begin
                    step_d = step_q + STEP_W'(1);
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
                step_d  = '0;
            end
            default: begin
                state_d = ST_IDLE;
                step_d  = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // outputs
    always_comb begin
        load    = (state_q == ST_IDLE) && start;
        running = (state_q == ST_RUN);
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FINISH);
        step    = step_q;
    end

    a_r10_abort_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && abort) |=> (state_q == ST_IDLE && step_q == $past(step_q)));
    a_r11_resume_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && resume && !vl_zero) |=> (step_q == $past(step_q)));
    a_r12_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && vl_zero) |=> done);
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/vloop_elem.sv
module vloop_elem #(
    parameter int MAXVL  = 8,
    parameter int STEP_W = 3,
    parameter int VL_W   = 4
) (
    input  logic [STEP_W-1:0] step,
    input  logic [VL_W-1:0]   vl,
    input  logic              rev,
    input  logic              pen,
    input  logic [MAXVL-1:0]  mask,
    output logic [STEP_W-1:0] idx,
    output logic              active,
    output logic              last
);
    logic [VL_W-1:0] vl_m1;

    always_comb begin
        vl_m1  = vl - VL_W'(1);
        last   = (VL_W'(step) == vl_m1);
        idx    = rev ? STEP_W'(vl_m1 - VL_W'(step)) : step;
        active = !pen || mask[idx];
    end
endmodule

// File: rtl/vloop_agen.sv
module vloop_agen #(
    parameter int REG_W  = 7,
    parameter int STEP_W = 3
) (
    input  logic [REG_W-1:0]  base,
    input  logic              vec,
    input  logic [STEP_W-1:0] idx,
    output logic [REG_W-1:0]  regnum
);
    always_comb regnum = vec ? base + REG_W'(idx) : base;
endmodule

// File: rtl/vloop_seq.sv
module vloop_seq #(
    parameter int MAXVL  = 8,
    parameter int REG_W  = 7,
    parameter int VL_W   = $clog2(MAXVL + 1),
    parameter int STEP_W = $clog2(MAXVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_resume,
    input  logic              op_abort,
    input  logic [VL_W-1:0]   op_vl,
    input  logic              dst_vec,
    input  logic              srca_vec,
    input  logic              srcb_vec,
    input  logic [REG_W-1:0]  dst_base,
    input  logic [REG_W-1:0]  srca_base,
    input  logic [REG_W-1:0]  srcb_base,
    input  logic              pred_en,
    input  logic [MAXVL-1:0]  pred_mask,
    input  logic              map_reduce,
    input  logic              rev_order,
    output logic              busy,
    output logic              done,
    output logic              iss_valid,
    output logic [STEP_W-1:0] iss_idx,
    output logic [REG_W-1:0]  iss_dst,
    output logic [REG_W-1:0]  iss_srca,
    output logic [REG_W-1:0]  iss_srcb,
    output logic [STEP_W-1:0] loop_step
);
    localparam int NOPS = 3;

    logic [VL_W-1:0]             vl_q;
    logic [NOPS-1:0]             vec_q;
    logic [NOPS-1:0][REG_W-1:0]  base_q;
    logic [NOPS-1:0][REG_W-1:0]  regs;
    logic [MAXVL-1:0]            mask_q;
    logic                        pen_q, mr_q, rev_q;
    logic                        load, running, active, last, stop_early;
    logic [STEP_W-1:0]           step, idx;

    // operation fields captured on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q   <= '0;
            vec_q  <= '0;
            base_q <= '0;
            mask_q <= '0;
            pen_q  <= 1'b0;
            mr_q   <= 1'b0;
            rev_q  <= 1'b0;
        end else if (load) begin
            vl_q   <= op_vl;
            vec_q  <= {srcb_vec, srca_vec, dst_vec};
            base_q <= {srcb_base, srca_base, dst_base};
            mask_q <= pred_mask;
            pen_q  <= pred_en;
            mr_q   <= map_reduce;
            rev_q  <= rev_order;
        end
    end

    vloop_ctrl #(.STEP_W(STEP_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (op_start),
        .resume     (op_resume),
        .abort      (op_abort),
        .vl_zero    (op_vl == '0),
        .last_step  (last),
        .stop_early (stop_early),
        .load       (load),
        .running    (running),
        .busy       (busy),
        .done       (done),
        .step       (step)
    );

    vloop_elem #(.MAXVL(MAXVL), .STEP_W(STEP_W), .VL_W(VL_W)) u_elem (
        .step   (step),
        .vl     (vl_q),
        .rev    (rev_q),
        .pen    (pen_q),
        .mask   (mask_q),
        .idx    (idx),
        .active (active),
        .last   (last)
    );

    for (genvar g = 0; g < NOPS; g++) begin : g_agen
        vloop_agen #(.REG_W(REG_W), .STEP_W(STEP_W)) u_agen (
            .base   (base_q[g]),
            .vec    (vec_q[g]),
            .idx    (idx),
            .regnum (regs[g])
        );
    end

    always_comb begin
        stop_early = active && !vec_q[0] && !mr_q;
        iss_valid  = running && active && !op_abort;
        iss_idx    = idx;
        iss_dst    = regs[0];
        iss_srca   = regs[1];
        iss_srcb   = regs[2];
        loop_step  = step;
    end

    // order tracking used only by the assertions below
    logic              have_prev;
    logic [STEP_W-1:0] prev_idx;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_idx  <= '0;
        end else if (load) begin
            have_prev <= 1'b0;
        end else if (iss_valid) begin
            have_prev <= 1'b1;
            prev_idx  <= iss_idx;
        end
    end

    a_r5_first_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !vec_q[0] && !mr_q) |=> (done && !iss_valid));
    a_r3_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (!pen_q || mask_q[iss_idx]));
    a_r7_order: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && have_prev) |-> (rev_q ? (iss_idx < prev_idx) : (iss_idx > prev_idx)));
    a_r8_same_elem: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && vec_q[0] && vec_q[1]) |-> ((iss_dst - base_q[0]) == (iss_srca - base_q[1])));
    a_r9_step_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (loop_step == '0));
    a_r9_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (VL_W'(loop_step) < vl_q));
endmodule

// File: tb/vloop_seq_test.sv
`timescale 1ns/1ps
module vloop_seq_test;
    logic       clk = 0, rst_n = 0;
    logic       op_start = 0, op_resume = 0, op_abort = 0;
    logic [3:0] op_vl = 0;
    logic       dst_vec = 0, srca_vec = 0, srcb_vec = 0;
    logic [6:0] dst_base = 0, srca_base = 0, srcb_base = 0;
    logic       pred_en = 0, map_reduce = 0, rev_order = 0;
    logic [7:0] pred_mask = 0;
    logic       busy, done, iss_valid;
    logic [2:0] iss_idx, loop_step;
    logic [6:0] iss_dst, iss_srca, iss_srcb;

    int total = 0, bad = 0;
    int saved_step = 0;

    always #10 clk = ~clk;

    vloop_seq uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_resume(op_resume),
        .op_abort(op_abort), .op_vl(op_vl), .dst_vec(dst_vec), .srca_vec(srca_vec),
        .srcb_vec(srcb_vec), .dst_base(dst_base), .srca_base(srca_base),
        .srcb_base(srcb_base), .pred_en(pred_en), .pred_mask(pred_mask),
        .map_reduce(map_reduce), .rev_order(rev_order), .busy(busy), .done(done),
        .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_dst(iss_dst),
        .iss_srca(iss_srca), .iss_srcb(iss_srcb), .loop_step(loop_step)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one operation; first step comes from saved_step when res=1
    task automatic run_op(input int vl, input bit rev, input bit dv, input bit av,
                          input bit bv, input bit pen, input bit mr,
                          input logic [7:0] mask, input bit res, input bit poke,
                          input int abort_at);
        int first;
        bit stop;
        stop  = 0;
        first = res ? saved_step : 0;
        @(negedge clk);
        op_vl = 4'(vl); rev_order = rev; dst_vec = dv; srca_vec = av; srcb_vec = bv;
        pred_en = pen; map_reduce = mr; pred_mask = mask;
        dst_base = 7'd124; srca_base = 7'd10; srcb_base = 7'd64;
        op_start = 1; op_resume = res;
        @(negedge clk);
        op_start = 0; op_resume = 0;
        if (poke) begin
            op_start = 1; op_vl = 4'd1; dst_base = 7'd3; pred_mask = 8'hFF;
            rev_order = ~rev; map_reduce = ~mr;
        end
        for (int s = first; s < vl; s++) begin
            int  idx;
            bit  act;
            idx = rev ? vl - 1 - s : s;
            act = !pen || mask[idx];
            if (s == abort_at) begin
                op_abort = 1; #1;
                chk(iss_valid == 0, "R10 issue suppressed on abort", iss_valid, 0);
                @(negedge clk);
                op_abort = 0; op_start = 0; #1;
                chk(busy == 0 && done == 0, "R10 idle without done", {busy, done}, 0);
                chk(loop_step == 3'(s), "R10 step kept", loop_step, s);
                saved_step = s;
                return;
            end
            #1;
            chk(busy == 1, "R1 busy in loop", busy, 1);
            chk(loop_step == 3'(s), "R9 step visible", loop_step, s);
            chk(iss_valid == act, pen ? "R3 predicate gating" : "R2 no predicate all on",
                iss_valid, act);
            if (act) begin
                chk(iss_idx == 3'(idx), "R7 element index", iss_idx, idx);
                chk(iss_dst == (dv ? 7'(124 + idx) : 7'd124), mr ? "R6 accumulator dst" : "R4 dst reg",
                    iss_dst, dv ? (124 + idx) % 128 : 124);
                chk(iss_srca == (av ? 7'(10 + idx) : 7'd10), "R8 srca reg", iss_srca,
                    av ? 10 + idx : 10);
                chk(iss_srcb == (bv ? 7'(64 + idx) : 7'd64), "R4 srcb reg", iss_srcb,
                    bv ? 64 + idx : 64);
                if (!dv && !mr) stop = 1;
            end
            @(negedge clk);
            if (stop) break;
        end
        op_start = 0; #1;
        chk(done == 1, stop ? "R5 early end done" : (vl == 0 ? "R12 empty done" : "R13 done after last"),
            done, 1);
        chk(loop_step == 0, "R9 step zero at done", loop_step, 0);
        chk(iss_valid == 0, "R13 no issue at done", iss_valid, 0);
        @(negedge clk); #1;
        chk(done == 0 && busy == 0, "R13 done single pulse", {done, busy}, 0);
        saved_step = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] masks [4];
        masks[0] = 8'hA5; masks[1] = 8'h00; masks[2] = 8'h80; masks[3] = 8'h01;
        repeat (3) @(negedge clk);
        #1;
        chk(busy == 0 && done == 0 && iss_valid == 0, "R1 reset idle", {busy, done, iss_valid}, 0);
        chk(loop_step == 0, "R9 reset step", loop_step, 0);
        rst_n = 1;

        for (int vl = 0; vl <= 8; vl++)
            for (int rev = 0; rev < 2; rev++)
                for (int mode = 0; mode < 4; mode++)
                    for (int m = 0; m < 5; m++) begin
                        bit dv, av, bv, mr;
                        dv = (mode == 0 || mode == 3);
                        mr = (mode == 2);
                        av = (mode != 3);
                        bv = (mode == 0);
                        if (m == 4) run_op(vl, rev[0], dv, av, bv, 1'b0, mr, 8'h00, 0, 0, -1);
                        else        run_op(vl, rev[0], dv, av, bv, 1'b1, mr, masks[m], 0, 0, -1);
                    end

        // R1: start held high during a run has no effect
        run_op(6, 0, 1, 1, 1, 0, 0, 8'h00, 0, 1, -1);
        run_op(5, 1, 0, 1, 0, 1, 1, 8'h16, 0, 1, -1);

        // R10 / R11: abort then resume, forward and reverse
        run_op(8, 0, 1, 1, 0, 0, 0, 8'h00, 0, 0, 3);
        run_op(8, 0, 1, 1, 0, 0, 0, 8'h00, 1, 0, -1);
        run_op(7, 1, 0, 1, 1, 1, 1, 8'h5B, 0, 0, 5);
        run_op(7, 1, 0, 1, 1, 1, 1, 8'h5B, 1, 0, -1);
        run_op(4, 0, 1, 0, 0, 1, 0, 8'h0E, 0, 0, 0);
        run_op(4, 0, 1, 0, 0, 1, 0, 8'h0E, 1, 0, -1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule